// File: doc/BRIEF.md
# SMBus Slave Receive Engine with Host-Decided Acknowledge

This block is the receive side of an SMBus/I2C slave. It watches the bus clock and data lines through a synchronizer and a small majority filter, and it recognises START and STOP conditions. It shifts in an address byte and then any data bytes that follow. Each accepted byte is handed to host logic through a data register, an acknowledge-request flag and an interrupt pulse.

The hardware never decides the acknowledge itself. After every accepted byte it holds the bus clock low until the host writes an ACK or NACK choice. It then drives that choice in the ninth clock. If the host refuses an address, or refuses a data byte, the block stays silent until the next START. A repeated START restarts address reception at once. A host write to the data register during an active receive is reported as a request to switch to transmit mode. The block drives both bus lines only through open-drain pull-down enables.

Top module: `smb_slave_rx`

## Requirements
- R1: A falling SDA while SCL is high (START) begins address reception. A rising SDA while SCL is high (STOP) returns the block to idle, with `rx_active` at 0.
- R2: Bits are sampled on the SCL rising edge, MSB first. When `inhibit` is 0 and the first byte after START has bits 7:1 equal to `own_addr` and bit 0 equal to 0 (write), the block sets `rx_active` and `ack_req`, pulses `irq` for one cycle, and loads the address byte into `rx_data`.
- R3: While `inhibit` is 1 at address completion, no address is accepted. There is no `ack_req`, no `irq`, no ACK on SDA and no clock stretch until the next START.
- R4: An address byte whose upper seven bits differ from `own_addr`, or whose bit 0 is 1 (read), is ignored in the same way as in R3.
- R5: After an acknowledged address, each further byte is loaded into `rx_data`, sets `ack_req` and pulses `irq` once. This happens at the eighth rising SCL edge, before the ninth clock.
- R6: After an accepted byte, `scl_oe` is 1 from the falling SCL edge that follows the eighth bit. It returns to 0 one system clock after the `ack_wr` write that clears `ack_req` (or one clock after that falling edge, whichever is later).
- R7: `ack_wr` is taken only while `ack_req` is 1. `ack_val`=1 means ACK: `sda_oe` is 1 during the ninth clock. `ack_val`=0 means NACK: SDA is left released. An `ack_wr` with `ack_req` at 0 changes nothing.
- R8: After a NACKed address or a NACKed data byte, no `ack_req` or `irq` is raised and no ACK is driven until a new START. After that START, a matching address is accepted again.
- R9: A STOP ends receive mode after any number of data bytes, including zero.
- R10: A repeated START during a transfer restarts address reception without first passing through idle.
- R11: A `dat_wr` pulse while `rx_active` is 1 gives a one-cycle `tx_switch` pulse on the next clock. A `dat_wr` pulse at any other time gives none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK bit) |
| own_addr | input | 7 | Slave address to match |
| inhibit | input | 1 | 1 disables acceptance of any address |
| ack_wr | input | 1 | Host strobe writing the acknowledge choice |
| ack_val | input | 1 | Acknowledge choice, 1 = ACK, 0 = NACK |
| dat_wr | input | 1 | Host strobe writing the data register |
| rx_data | output | 8 | Last accepted byte |
| ack_req | output | 1 | Acknowledge decision pending |
| irq | output | 1 | One-cycle pulse per accepted byte |
| rx_active | output | 1 | Block is an addressed slave receiver |
| tx_switch | output | 1 | One-cycle request to switch to transmit mode |

## Verification
The bench builds the block with its defaults: two synchronizer stages and a three-tap majority filter. With these, each bus half-period of ten system clocks gives settled values at every sampling point. Because the address is only seven bits wide, all 128 addresses are swept against a fixed `own_addr`, and the read direction is tried on the matching address. The bench also runs sixteen own-address and data pairs, plus every NACK, inhibit and repeated-START ordering. For each of these it compares `rx_data`, the interrupt count, the stretch window and the ACK seen on the wired bus against values it computes itself.

// File: rtl/smb_rx_pkg.sv
`timescale 1ns/1ps
package smb_rx_pkg;
  localparam int SMB_BYTE_W = 8;
  localparam int SMB_ADDR_W = SMB_BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_HOLD, ST_ACK9, ST_DATA, ST_WAIT
  } rx_state_t;

  // address byte accepted: upper bits match, direction bit is write
  function automatic logic addr_hit(input logic [SMB_BYTE_W-1:0] b,
                                    input logic [SMB_ADDR_W-1:0] own,
                                    input logic inh);
    return !inh && !b[0] && (b[SMB_BYTE_W-1:1] == own);
  endfunction
endpackage

// File: rtl/smb_line_filter.sv
`timescale 1ns/1ps
module smb_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        win_q;
  logic                   out_q;

  function automatic logic vote(input logic [TAPS-1:0] w);
    int n;
    n = 0;
    for (int i = 0; i < TAPS; i++) n = n + (w[i] ? 1 : 0);
    return n > (TAPS / 2);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      win_q  <= {win_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      out_q  <= vote(win_q);
    end
  end

  assign clean_o = out_q;
endmodule

// File: rtl/smb_bus_events.sv
`timescale 1ns/1ps
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/smb_rx_ctrl.sv
`timescale 1ns/1ps
module smb_rx_ctrl
  import smb_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_ev,
  input  logic                  stop_ev,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  sda_f,
  input  logic [SMB_ADDR_W-1:0] own_addr,
  input  logic                  inhibit,
  input  logic                  ack_wr,
  input  logic                  ack_val,
  input  logic                  dat_wr,
  output logic                  stretch_o,
  output logic                  sda_drv_o,
  output logic [SMB_BYTE_W-1:0] rx_data_o,
  output logic                  ack_req_o,
  output logic                  irq_o,
  output logic                  active_o,
  output logic                  tx_sw_o
);
  localparam int CNT_W = $clog2(SMB_BYTE_W);

  rx_state_t             state_q;
  logic [SMB_BYTE_W-1:0] shift_q, rx_data_q;
  logic [CNT_W-1:0]      bitcnt_q;
  logic fell_q, stretch_q, sda_drv_q, ack_bit_q, ack_req_q, irq_q, tx_sw_q;

  logic [SMB_BYTE_W-1:0] byte_nxt;
  logic                  last_bit, hit, active;

  assign byte_nxt = {shift_q[SMB_BYTE_W-2:0], sda_f};
  assign last_bit = (bitcnt_q == CNT_W'(SMB_BYTE_W - 1));
  assign hit      = addr_hit(byte_nxt, own_addr, inhibit);
  assign active   = (state_q == ST_HOLD) || (state_q == ST_ACK9) || (state_q == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      rx_data_q <= '0;
      bitcnt_q  <= '0;
      fell_q    <= 1'b0;
      stretch_q <= 1'b0;
      sda_drv_q <= 1'b0;
      ack_bit_q <= 1'b0;
      ack_req_q <= 1'b0;
      irq_q     <= 1'b0;
      tx_sw_q   <= 1'b0;
    end else begin
      irq_q   <= 1'b0;
      tx_sw_q <= dat_wr && active;
      if (ack_wr && ack_req_q) begin
        ack_req_q <= 1'b0;
        ack_bit_q <= ack_val;
      end
      if (start_ev || stop_ev) begin
        state_q   <= start_ev ? ST_ADDR : ST_IDLE;
        bitcnt_q  <= '0;
        fell_q    <= 1'b0;
        stretch_q <= 1'b0;
        sda_drv_q <= 1'b0;
        ack_req_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise) begin
              shift_q <= byte_nxt;
              if (last_bit) begin
                bitcnt_q <= '0;
                if (state_q == ST_DATA || hit) begin
                  rx_data_q <= byte_nxt;
                  ack_req_q <= 1'b1;
                  irq_q     <= 1'b1;
                  fell_q    <= 1'b0;
                  state_q   <= ST_HOLD;
                end else begin
                  state_q <= ST_WAIT;
                end
              end else begin
                bitcnt_q <= bitcnt_q + 1'b1;
              end
            end
          end
          ST_HOLD: begin
            if (scl_fall) begin
              fell_q    <= 1'b1;
              stretch_q <= 1'b1;
            end
            if (fell_q && !ack_req_q) begin
              state_q   <= ST_ACK9;
              sda_drv_q <= ack_bit_q;
              stretch_q <= 1'b0;
            end
          end
          ST_ACK9: begin
            if (scl_fall) begin
              sda_drv_q <= 1'b0;
              state_q   <= ack_bit_q ? ST_DATA : ST_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign stretch_o = stretch_q;
  assign sda_drv_o = sda_drv_q;
  assign rx_data_o = rx_data_q;
  assign ack_req_o = ack_req_q;
  assign irq_o     = irq_q;
  assign active_o  = active;
  assign tx_sw_o   = tx_sw_q;
endmodule

// File: rtl/smb_slave_rx.sv
`timescale 1ns/1ps
module smb_slave_rx
  import smb_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  scl_oe,
  output logic                  sda_oe,
  input  logic [SMB_ADDR_W-1:0] own_addr,
  input  logic                  inhibit,
  input  logic                  ack_wr,
  input  logic                  ack_val,
  input  logic                  dat_wr,
  output logic [SMB_BYTE_W-1:0] rx_data,
  output logic                  ack_req,
  output logic                  irq,
  output logic                  rx_active,
  output logic                  tx_switch
);
  logic scl_f, sda_f;
  logic start_ev, stop_ev, scl_rise, scl_fall;

  smb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) scl_filt_i (
    .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_f));

  smb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) sda_filt_i (
    .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_f));

  smb_bus_events evt_i (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  smb_rx_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_f(sda_f),
    .own_addr(own_addr), .inhibit(inhibit),
    .ack_wr(ack_wr), .ack_val(ack_val), .dat_wr(dat_wr),
    .stretch_o(scl_oe), .sda_drv_o(sda_oe), .rx_data_o(rx_data),
    .ack_req_o(ack_req), .irq_o(irq), .active_o(rx_active),
    .tx_sw_o(tx_switch));
endmodule

// File: rtl/smb_slave_rx_chk.sv
`timescale 1ns/1ps
module smb_slave_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic ack_req,
  input logic irq,
  input logic rx_active,
  input logic tx_switch
);
  // R2
  irq_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ack_req);

  // R5
  req_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> rx_active);

  // R6
  release_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_req) |=> !scl_oe);

  // R7
  ack_under_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_oe));

  // R11
  tx_switch_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_switch |-> $past(rx_active));
endmodule

bind smb_slave_rx smb_slave_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .ack_req(ack_req), .irq(irq), .rx_active(rx_active), .tx_switch(tx_switch));

// File: tb/smb_slave_rx_tb_top.sv
`timescale 1ns/1ps
module smb_slave_rx_tb_top;
  localparam int H   = 10;
  localparam int OWN = 42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic [6:0] own_addr = 7'(OWN);
  logic inhibit = 1'b0, ack_wr = 1'b0, ack_val = 1'b0, dat_wr = 1'b0;
  logic [7:0] rx_data;
  logic ack_req, irq, rx_active, tx_switch;
  int nchk = 0, nbad = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  smb_slave_rx dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .inhibit(inhibit),
    .ack_wr(ack_wr), .ack_val(ack_val), .dat_wr(dat_wr), .rx_data(rx_data),
    .ack_req(ack_req), .irq(irq), .rx_active(rx_active), .tx_switch(tx_switch));

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wait_high(); wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wait_high(); wt(H);
    sda_m = 1'b1; wt(2 * H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wt(H);
    scl_m = 1'b1; wait_high(); wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  // master sends one byte; host answers if a request is expected
  task automatic send_byte(input logic [7:0] b, input bit exp_req,
                           input bit host_ack, input string tag);
    int irq0;
    bit acked;
    irq0 = irq_cnt;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    chk({tag, " ack_req"}, int'(ack_req), int'(exp_req));
    chk({tag, " irq count"}, irq_cnt - irq0, int'(exp_req));
    chk({tag, " R6 stretch on"}, int'(scl_oe), int'(exp_req));
    if (exp_req) chk({tag, " rx_data"}, int'(rx_data), int'(b));
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1;
    if (exp_req) begin
      wt(12);
      chk({tag, " R6 scl held"}, int'(scl_line), 0);
      ack_wr = 1'b1; ack_val = host_ack;
      @(negedge clk);
      ack_wr = 1'b0;
      chk({tag, " R7 req cleared"}, int'(ack_req), 0);
      chk({tag, " R6 still held"}, int'(scl_oe), 1);
      @(negedge clk);
      chk({tag, " R6 released"}, int'(scl_oe), 0);
      chk({tag, " R7 sda drive"}, int'(sda_oe), int'(host_ack));
    end else begin
      wt(4);
      chk({tag, " R6 no stretch"}, int'(scl_line), 1);
    end
    wait_high(); wt(H);
    acked = !sda_line;
    chk({tag, " R7 bus ack"}, int'(acked), int'(exp_req && host_ack));
    scl_m = 1'b0; wt(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    wt(5);
    chk("R1 reset scl_oe", int'(scl_oe), 0);
    chk("R1 reset sda_oe", int'(sda_oe), 0);
    chk("R1 reset ack_req", int'(ack_req), 0);
    chk("R1 reset active", int'(rx_active), 0);
    rst_n = 1'b1; wt(5);

    // R1 R2 R5 R9: basic write of two bytes
    bus_start();
    send_byte({7'(OWN), 1'b0}, 1, 1, "R2 addr");
    chk("R2 active", int'(rx_active), 1);
    send_byte(8'hA5, 1, 1, "R5 data0");
    send_byte(8'h3C, 1, 1, "R5 data1");
    bus_stop(); wt(4);
    chk("R9 stop ends", int'(rx_active), 0);

    // R2 R5: own address and data sweep
    for (int k = 0; k < 16; k++) begin
      own_addr = 7'(k * 8 + 3);
      bus_start();
      send_byte({own_addr, 1'b0}, 1, 1, "R2 own sweep");
      send_byte(8'(k * 17), 1, 1, "R5 data sweep");
      bus_stop();
    end
    own_addr = 7'(OWN);

    // R4: all addresses, write direction, then read on own
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, a == OWN, 1, "R4 addr sweep");
      bus_stop();
    end
    bus_start();
    send_byte({7'(OWN), 1'b1}, 0, 1, "R4 read dir");
    send_byte(8'h55, 0, 1, "R4 after read");
    bus_stop();

    // R3: inhibit
    inhibit = 1'b1;
    bus_start();
    send_byte({7'(OWN), 1'b0}, 0, 1, "R3 inhibit addr");
    send_byte(8'h81, 0, 1, "R3 inhibit data");
    bus_stop();
    inhibit = 1'b0;

    // R8: NACKed address mutes until START
    bus_start();
    send_byte({7'(OWN), 1'b0}, 1, 0, "R8 addr nack");
    send_byte(8'h12, 0, 1, "R8 muted");
    bus_start();
    send_byte({7'(OWN), 1'b0}, 1, 1, "R8 after start");
    bus_stop();

    // R8: NACKed data byte
    bus_start();
    send_byte({7'(OWN), 1'b0}, 1, 1, "R8 addr");
    send_byte(8'h77, 1, 0, "R8 data nack");
    send_byte(8'h78, 0, 1, "R8 data muted");
    bus_stop();

    // R9: zero data bytes
    bus_start();
    send_byte({7'(OWN), 1'b0}, 1, 1, "R9 addr only");
    bus_stop(); wt(4);
    chk("R9 zero bytes idle", int'(rx_active), 0);
    chk("R9 zero bytes req", int'(ack_req), 0);

    // R10: repeated START
    bus_start();
    send_byte({7'(OWN), 1'b0}, 1, 1, "R10 addr1");
    send_byte(8'hC3, 1, 1, "R10 data1");
    bus_start();
    send_byte({7'(OWN), 1'b0}, 1, 1, "R10 addr2");
    send_byte(8'h0F, 1, 1, "R10 data2");
    bus_stop();

    // R11 and R7 stray ack_wr
    dat_wr = 1'b1; @(negedge clk); dat_wr = 1'b0;
    chk("R11 idle no switch", int'(tx_switch), 0);
    bus_start();
    send_byte({7'(OWN), 1'b0}, 1, 1, "R11 addr");
    ack_wr = 1'b1; ack_val = 1'b1; @(negedge clk); ack_wr = 1'b0;
    chk("R7 stray ack_wr req", int'(ack_req), 0);
    chk("R7 stray ack_wr sda", int'(sda_oe), 0);
    dat_wr = 1'b1; @(negedge clk); dat_wr = 1'b0;
    chk("R11 switch pulse", int'(tx_switch), 1);
    @(negedge clk);
    chk("R11 switch one cycle", int'(tx_switch), 0);
    send_byte(8'h99, 1, 1, "R11 data");
    bus_stop();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule